// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a register-mapped general-purpose I/O controller for a small group of pins (8 or 12 in practice, up to 16 by parameter). A 32-bit register bus with a write strobe, a read strobe, a byte address and write data lets software choose each pin's direction, set the driven value and read back the sampled pad level. The bus data are registered on the clock edge that accepts a read.

Each pin passes through a two-flop synchronizer and then an event detector. The detector has five trigger kinds: rising edge, falling edge, either edge, high level and low level. A detected event on an enabled pin sets a sticky pending bit. Software masks and unmasks pins through separate write-one-to-set and write-one-to-clear registers. It acknowledges pending bits by writing ones to a clear register. The pending bits that are enabled and unmasked are ORed into a single interrupt line. A soft-reset register returns the whole configuration to its power-up values and holds it there until software writes the register back to zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0. Both mask registers read all ones over the pin count. Pending, direction, output, the mode registers and the pin-use register read 0, and `irq_out` is 0.
- R2: `pin_oe` equals the direction register at byte offset 0x20, where 1 means output. `pin_out` equals the output register at 0x18. The input register at 0x1C returns `pin_in` after two clock edges of synchronization.
- R3: A pin in mode 1 sets its pending bit on a 0-to-1 transition only. A pin in mode 0 sets it on a 1-to-0 transition only.
- R4: A pin in mode 4 sets its pending bit on both transitions.
- R5: A pin in mode 3 (high) or mode 2 (low) sets its pending bit on every cycle that the synchronized level is active. A clear written while the level persists therefore leaves the bit set.
- R6: A pin whose bit in the enable register (0x00) is 0 never sets its pending bit.
- R7: Writing ones to 0x10 sets those mask bits and writing ones to 0x14 clears them. Zero bits leave the mask unchanged. Both offsets read back the mask.
- R8: Writing ones to 0x0C clears those pending bits (status at 0x04, bit i = pin i). When a set and a clear land on the same bit in the same cycle, the bit stays set.
- R9: `irq_out` is 1 exactly when some pin is pending, enabled and unmasked. Offset 0x08 reads pending AND NOT mask.
- R10: The mode of pin n occupies bits [4k+2:4k]. For n < 8 it sits in the register at 0x24 with k = n, and for n >= 8 in the register at 0x28 with k = n-8. Bit 4k+3 reads 0.
- R11: Reads of 0x2C to 0x34, and of the clear register 0x0C, return 0, and writes to 0x2C to 0x34 have no effect. The pin-use register at 0x38 is a plain read/write register.
- R12: Writing 1 to bit 0 of 0x3C returns every control, pending and mode field to its reset value. While that bit stays 1, writes to other offsets are ignored. Writing 0 releases the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appear after the edge |
| bus_addr | input | 6 | Byte address, bits [5:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pad input levels |
| pin_out | output | PIN_COUNT | Output data to the pad drivers |
| pin_oe | output | PIN_COUNT | Output enable per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `bus_we` and `bus_rd` are never both set in the same cycle and that the address is stable while a strobe is high. They also assume that `pin_in` may change at any time, because every check on it is made after synchronization. The stimulus drives all bus and pin inputs only at falling clock edges and holds each strobe for exactly one cycle. It changes a pin only after the previous pin event has fully settled, except in the one case that deliberately aligns an acknowledge with an arriving edge.

// File: rtl/gpioirq_pkg.sv
package gpioirq_pkg;
    localparam int MODE_W       = 3;
    localparam int NIBBLE_W     = 4;
    localparam int PINS_PER_REG = 8;

    typedef enum logic [3:0] {
        RI_EN    = 4'h0,
        RI_STAT  = 4'h1,
        RI_DISP  = 4'h2,
        RI_CLR   = 4'h3,
        RI_MSET  = 4'h4,
        RI_MCLR  = 4'h5,
        RI_DOUT  = 4'h6,
        RI_DIN   = 4'h7,
        RI_DIR   = 4'h8,
        RI_MODE0 = 4'h9,
        RI_MODE1 = 4'hA,
        RI_USE   = 4'hE,
        RI_SRST  = 4'hF
    } reg_idx_e;

    typedef enum logic [2:0] {
        DM_FALL = 3'd0,
        DM_RISE = 3'd1,
        DM_LOW  = 3'd2,
        DM_HIGH = 3'd3,
        DM_BOTH = 3'd4
    } det_mode_e;
endpackage

// File: rtl/gpioirq_sync2.sv
module gpioirq_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpioirq_det.sv
module gpioirq_det
    import gpioirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_async,
    input  logic [MODE_W-1:0] mode,
    output logic              level,
    output logic              event_hit
);
    logic samp;
    logic prev_d, prev_q;
    logic rise, fall;

    gpioirq_sync2 #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_async),
        .q     (samp)
    );

    always_comb begin
        prev_d = samp;
        rise   = samp & ~prev_q;
        fall   = ~samp & prev_q;
        case (mode)
            DM_FALL: event_hit = fall;
            DM_RISE: event_hit = rise;
            DM_LOW:  event_hit = ~samp;
            DM_HIGH: event_hit = samp;
            DM_BOTH: event_hit = rise | fall;
            default: event_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign level = samp;

    // R3: a rising-only detector never reports while the sampled level is low
    p_rise_only_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DM_RISE && event_hit) |-> samp);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpioirq_pkg::*;
#(
    parameter int PIN_COUNT = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic                 bus_rd,
    input  logic [5:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq_out
);
    localparam int N      = PIN_COUNT;
    localparam int LO_CNT = (N < PINS_PER_REG) ? N : PINS_PER_REG;
    localparam logic [N-1:0] MASK_ALL = {N{1'b1}};

    typedef struct packed {
        logic [N-1:0]        en;
        logic [N-1:0]        pend;
        logic [N-1:0]        mask;
        logic [N-1:0]        dout;
        logic [N-1:0]        dir;
        logic [N-1:0]        use_sel;
        logic [N*MODE_W-1:0] modes;
        logic                srst;
        logic [31:0]         rdata;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0] evt_vec, lvl_vec, set_vec, clr_bits, wmask;
    logic [3:0]   widx;
    logic         wr_ok;
    logic [31:0]  mode_lo_rd, mode_hi_rd, rd_val;
    logic         unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    // one synchronizer and detector per pin
    for (genvar g = 0; g < N; g++) begin : g_pin
        gpioirq_det u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[g]),
            .mode      (s_q.modes[g*MODE_W +: MODE_W]),
            .level     (lvl_vec[g]),
            .event_hit (evt_vec[g])
        );
    end

    // read-side assembly of the mode registers
    always_comb begin
        mode_lo_rd = '0;
        mode_hi_rd = '0;
        for (int i = 0; i < LO_CNT; i++)
            mode_lo_rd[i*NIBBLE_W +: MODE_W] = s_q.modes[i*MODE_W +: MODE_W];
        for (int i = PINS_PER_REG; i < N; i++)
            mode_hi_rd[(i-PINS_PER_REG)*NIBBLE_W +: MODE_W] = s_q.modes[i*MODE_W +: MODE_W];
    end

    always_comb begin
        case (bus_addr[5:2])
            RI_EN:    rd_val = 32'(s_q.en);
            RI_STAT:  rd_val = 32'(s_q.pend);
            RI_DISP:  rd_val = 32'(s_q.pend & ~s_q.mask);
            RI_MSET,
            RI_MCLR:  rd_val = 32'(s_q.mask);
            RI_DOUT:  rd_val = 32'(s_q.dout);
            RI_DIN:   rd_val = 32'(lvl_vec);
            RI_DIR:   rd_val = 32'(s_q.dir);
            RI_MODE0: rd_val = mode_lo_rd;
            RI_MODE1: rd_val = mode_hi_rd;
            RI_USE:   rd_val = 32'(s_q.use_sel);
            RI_SRST:  rd_val = {31'd0, s_q.srst};
            default:  rd_val = '0;
        endcase
    end

    // next-state computation
    always_comb begin
        s_d      = s_q;
        widx     = bus_addr[5:2];
        wmask    = bus_wdata[N-1:0];
        clr_bits = '0;
        set_vec  = evt_vec & s_q.en;
        wr_ok    = bus_we && (!s_q.srst || widx == RI_SRST);

        if (wr_ok) begin
            case (widx)
                RI_EN:    s_d.en      = wmask;
                RI_CLR:   clr_bits    = wmask;
                RI_MSET:  s_d.mask    = s_q.mask | wmask;
                RI_MCLR:  s_d.mask    = s_q.mask & ~wmask;
                RI_DOUT:  s_d.dout    = wmask;
                RI_DIR:   s_d.dir     = wmask;
                RI_USE:   s_d.use_sel = wmask;
                RI_SRST:  s_d.srst    = bus_wdata[0];
                RI_MODE0: begin
                    for (int i = 0; i < LO_CNT; i++)
                        s_d.modes[i*MODE_W +: MODE_W] = bus_wdata[i*NIBBLE_W +: MODE_W];
                end
                RI_MODE1: begin
                    for (int i = PINS_PER_REG; i < N; i++)
                        s_d.modes[i*MODE_W +: MODE_W] =
                            bus_wdata[(i-PINS_PER_REG)*NIBBLE_W +: MODE_W];
                end
                default: ;
            endcase
        end

        // a new event outranks an acknowledge in the same cycle
        s_d.pend = (s_q.pend & ~clr_bits) | set_vec;

        if (s_q.srst || s_d.srst) begin
            s_d.en      = '0;
            s_d.pend    = '0;
            s_d.mask    = MASK_ALL;
            s_d.dout    = '0;
            s_d.dir     = '0;
            s_d.use_sel = '0;
            s_d.modes   = '0;
        end

        if (bus_rd) s_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mask  <= MASK_ALL;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign pin_out   = s_q.dout;
    assign pin_oe    = s_q.dir;
    assign irq_out   = |(s_q.pend & s_q.en & ~s_q.mask);

    // R7: mask-set write leaves every written one set
    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[5:2] == RI_MSET && !s_q.srst)
        |=> ((s_q.mask & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    // R8: acknowledged bits with no coincident event are cleared
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[5:2] == RI_CLR && !s_q.srst)
        |=> ((s_q.pend & $past(bus_wdata[N-1:0] & ~evt_vec)) == '0));

    // R9: no interrupt request without some pending bit
    p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend == '0) |-> !irq_out);

    // R12: while soft reset is held the state sits at reset values
    p_srst_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.srst |-> (s_q.pend == '0 && s_q.en == '0 && s_q.dir == '0 && s_q.mask == MASK_ALL));

    // R6: a pending bit only rises on a pin that was enabled
    for (genvar g = 0; g < N; g++) begin : g_chk
        p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(s_q.pend[g]) |-> $past(s_q.en[g]));
    end
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
    localparam int N = 12;
    localparam logic [5:0] A_EN = 6'h00, A_STAT = 6'h04, A_DISP = 6'h08, A_CLR = 6'h0C,
                           A_MSET = 6'h10, A_MCLR = 6'h14, A_DOUT = 6'h18, A_DIN = 6'h1C,
                           A_DIR = 6'h20, A_MODE0 = 6'h24, A_MODE1 = 6'h28, A_RSV0 = 6'h2C,
                           A_RSV1 = 6'h30, A_RSV2 = 6'h34, A_USE = 6'h38, A_SRST = 6'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0, bus_rd = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.PIN_COUNT(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compares each registered read against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                #1;
                if (sb.size() > 0) begin
                    item_t it;
                    it = sb.pop_front();
                    chk(bus_rdata, it.exp, it.tag);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk(32'(irq_out), 0, "R1 irq after reset");
        chk(32'(pin_oe), 0, "R1 pin_oe after reset");
        rd(A_EN,    32'h0,   "R1 enable");
        rd(A_MSET,  32'hFFF, "R1 mask");
        rd(A_STAT,  32'h0,   "R1 status");
        rd(A_DIR,   32'h0,   "R1 direction");
        rd(A_MODE0, 32'h0,   "R1 mode0");
        rd(A_USE,   32'h0,   "R1 pin-use");

        // R2 direction, output, synchronized input
        wr(A_DIR, 32'h0A5);
        wr(A_DOUT, 32'h0F0);
        chk(32'(pin_oe), 32'h0A5, "R2 pin_oe");
        chk(32'(pin_out), 32'h0F0, "R2 pin_out");
        rd(A_DIR, 32'h0A5, "R2 direction readback");
        pin_in = 12'h3C3;
        step(2);
        rd(A_DIN, 32'h3C3, "R2 input after two edges");
        pin_in = 12'h010;
        step(3);
        rd(A_STAT, 32'h0, "R6 toggles with all enables off");

        // R10 mode layout, nibble bit 3 dropped
        wr(A_MODE0, 32'h0002_3409);
        rd(A_MODE0, 32'h0002_3401, "R10 mode0 fields");
        wr(A_MODE1, 32'h0000_0010);
        rd(A_MODE1, 32'h0000_0010, "R10 mode1 pin9 field");

        wr(A_EN, 32'h21F);
        wr(A_MCLR, 32'h00F);
        rd(A_MSET, 32'hFF0, "R7 mask after clear-ones");
        rd(A_MCLR, 32'hFF0, "R7 mask via clear offset");

        // R3 rising on pin0
        pin_in = 12'h011; step(3);
        rd(A_STAT, 32'h001, "R3 rising pin0");
        chk(32'(irq_out), 1, "R9 irq pin0 unmasked");
        rd(A_DISP, 32'h001, "R9 display pin0");
        wr(A_CLR, 32'h001);
        rd(A_STAT, 32'h0, "R8 clear pin0");
        chk(32'(irq_out), 0, "R9 irq after clear");
        pin_in = 12'h010; step(3);
        rd(A_STAT, 32'h0, "R3 falling ignored in rising mode");

        // R3 falling on pin1
        pin_in = 12'h012; step(3);
        rd(A_STAT, 32'h0, "R3 rising ignored in falling mode");
        pin_in = 12'h010; step(3);
        rd(A_STAT, 32'h002, "R3 falling pin1");
        wr(A_CLR, 32'h002);

        // R4 both edges on pin2
        pin_in = 12'h014; step(3);
        rd(A_STAT, 32'h004, "R4 both-edge rise");
        wr(A_CLR, 32'h004);
        pin_in = 12'h010; step(3);
        rd(A_STAT, 32'h004, "R4 both-edge fall");
        wr(A_CLR, 32'h004);

        // R5 level high on pin3
        pin_in = 12'h018; step(3);
        rd(A_STAT, 32'h008, "R5 level high set");
        wr(A_CLR, 32'h008);
        rd(A_STAT, 32'h008, "R5 level high reasserts after clear");
        pin_in = 12'h010; step(3);
        wr(A_CLR, 32'h008);
        rd(A_STAT, 32'h0, "R5 level high cleared after release");

        // R5 level low on pin4, masked
        pin_in = 12'h000; step(3);
        rd(A_STAT, 32'h010, "R5 level low set");
        chk(32'(irq_out), 0, "R9 masked pin4 no irq");
        rd(A_DISP, 32'h0, "R9 display hides masked pin4");
        pin_in = 12'h010; step(3);
        wr(A_CLR, 32'h010);
        rd(A_STAT, 32'h0, "R5 level low cleared after release");

        // R8 set wins against a coincident clear, pin9
        pin_in = 12'h210; step(2);
        wr(A_CLR, 32'h200);
        rd(A_STAT, 32'h200, "R8 set wins over clear");
        chk(32'(irq_out), 0, "R9 pin9 masked");
        wr(A_MCLR, 32'h200);
        chk(32'(irq_out), 1, "R7 unmask pin9 raises irq");
        rd(A_DISP, 32'h200, "R9 display pin9");
        wr(A_MSET, 32'h200);
        rd(A_MSET, 32'hFF0, "R7 zero bits keep mask");
        chk(32'(irq_out), 0, "R7 remask pin9");
        wr(A_CLR, 32'h200);
        rd(A_STAT, 32'h0, "R8 clear pin9");

        // R6 enable gating on pin0
        wr(A_EN, 32'h21E);
        pin_in = 12'h211; step(3);
        rd(A_STAT, 32'h0, "R6 disabled pin0 edge ignored");

        // R11 reserved and pin-use
        wr(A_RSV1, 32'hFFFF_FFFF);
        rd(A_RSV0, 32'h0, "R11 reserved 0x2C");
        rd(A_RSV1, 32'h0, "R11 reserved 0x30");
        rd(A_RSV2, 32'h0, "R11 reserved 0x34");
        rd(A_CLR, 32'h0, "R11 clear register reads zero");
        wr(A_USE, 32'hABC);
        rd(A_USE, 32'hABC, "R11 pin-use readback");

        // R12 soft reset
        wr(A_SRST, 32'h1);
        rd(A_EN,    32'h0,   "R12 enable reset");
        rd(A_MSET,  32'hFFF, "R12 mask reset");
        rd(A_MODE0, 32'h0,   "R12 mode0 reset");
        rd(A_USE,   32'h0,   "R12 pin-use reset");
        rd(A_SRST,  32'h1,   "R12 reset bit held");
        chk(32'(pin_oe), 0, "R12 pin_oe reset");
        wr(A_EN, 32'hFFF);
        rd(A_EN, 32'h0, "R12 write ignored while held");
        wr(A_SRST, 32'h0);
        rd(A_SRST, 32'h0, "R12 reset bit released");
        wr(A_EN, 32'h001);
        rd(A_EN, 32'h001, "R12 writes accepted after release");

        step(2);
        wait (sb.size() == 0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule